// File: doc/BRIEF.md
# Trap Delivery Level Register

This block is one privileged processor register that holds a small trap delivery level. Software writes it through a move-to-register port that carries a full 32-bit source operand, and reads it back through a move-from-register port. Each write is either stored or refused with a reserved-operand fault. The register is left unchanged on a refusal.

Processor families disagree on how the operand is checked, so a static mode input selects the behaviour. One mode compares the whole 32-bit operand against the limit. It does this by adding the negated limit and taking the carry-out as the fault. The result of that add is not used as a number, so signed overflow from it does not matter. A second mode keeps only the low three bits before testing them. The third mode keeps only the low three bits and never faults. Reset loads the level that means no trap is pending.

Top module: `ast_level_reg`

## Requirements
- R1: A synchronous reset sets the stored level to 4 and the read data to 4. It also clears the fault pulse and the write-accepted strobe.
- R2: A read captures the stored level into read-data bits 2:0 on the edge where the read strobe is sampled. Bits 31:3 of read data are always zero.
- R3: In mode 2'b00, a write faults when the full 32-bit source, taken as unsigned, is 5 or more. The stored level is then unchanged.
- R4: In mode 2'b00, the fault is the carry-out of the source plus 0xFFFFFFFB, and overflow from that add is ignored. For example, 0x80000002, 0x7FFFFFFF and 0xFFFFFFFF all fault, and 4 is accepted.
- R5: In mode 2'b01, only the low 3 bits of the source are kept before the test. The write faults only when those bits are 5, 6 or 7, and otherwise stores them. For example, 0x80000002 stores 2.
- R6: In mode 2'b10, the low 3 bits of the source are stored and no fault is ever raised, even when the value is 5 to 7.
- R7: Mode 2'b11 behaves exactly like mode 2'b00.
- R8: A refused write raises the fault output for one cycle, on the edge that samples the write. It does not raise write-accepted.
- R9: An accepted write updates the level on the edge that samples the write. On that same edge, write-accepted rises for one cycle and fault stays low.
- R10: When a read and a write arrive in the same cycle, the read returns the level held before the write.
- R11: The stored level does not change in any cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Static compatibility mode select |
| wr_en | input | 1 | Move-to-register write strobe |
| wr_src | input | 32 | Write source operand |
| rd_en | input | 1 | Move-from-register read strobe |
| rd_data | output | 32 | Read result, with the level in bits 2:0 |
| level | output | 3 | Currently stored level |
| fault | output | 1 | Reserved-operand fault pulse |
| wr_ok | output | 1 | Write-accepted pulse |

## Verification
A wrong compare shows one cycle after the write. The fault and write-accepted pulses come out inverted, and the level output moves when it should hold, or holds when it should move. A carry taken from the wrong bit shows up only on high-bit operands such as 0x80000002, so those operands are included. A level that changes without a write strobe, or a read that samples after the update, is visible on the very next read.

// File: rtl/ast_level_reg.sv
module ast_level_reg #(
  parameter int W         = 32,
  parameter int LVL_W     = 3,
  parameter int LIMIT     = 5,
  parameter int RESET_LVL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_src,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             fault,
  output logic             wr_ok
);

  localparam logic [W-1:0] NEG_LIMIT = '0 - W'(LIMIT);

  logic           mask_first, quiet, carry, reject;
  logic [W-1:0]   opnd;

  assign mask_first = (mode == 2'b01);
  assign quiet      = (mode == 2'b10);
  assign opnd       = mask_first ? W'(wr_src[LVL_W-1:0]) : wr_src;
  assign carry      = 1'(({1'b0, opnd} + {1'b0, NEG_LIMIT}) >> W);
  assign reject     = carry & ~quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= LVL_W'(RESET_LVL);
      rd_data <= W'(RESET_LVL);
      fault   <= 1'b0;
      wr_ok   <= 1'b0;
    end else begin
      fault <= wr_en & reject;
      wr_ok <= wr_en & ~reject;
      if (wr_en & ~reject) level <= wr_src[LVL_W-1:0];
      if (rd_en) rd_data <= W'(level);
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[W-1:LVL_W] == '0);

  // R3 R7
  full_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (mode == 2'b00 || mode == 2'b11) && wr_src >= W'(LIMIT)) |=> fault);

  // R5
  mask_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b01 && wr_src[LVL_W-1:0] < LVL_W'(LIMIT)) |=> wr_ok);

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b10) |=> (wr_ok && !fault));

  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault && wr_ok));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> $stable(level));

  // R9
  accept_val_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rst) |=> (wr_ok -> level == $past(wr_src[LVL_W-1:0])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(level));

endmodule

// File: tb/ast_level_reg_tb.sv
module ast_level_reg_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        wr_en, rd_en;
  logic [31:0] wr_src;
  logic [31:0] rd_data;
  logic [2:0]  level;
  logic        fault, wr_ok;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ast_level_reg u_dut (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_src(wr_src),
    .rd_en(rd_en), .rd_data(rd_data), .level(level), .fault(fault), .wr_ok(wr_ok)
  );

  // {mode, source, expected fault, expected level after}
  localparam logic [37:0] VEC [16] = '{
    {2'b00, 32'h0000_0003, 1'b0, 3'd3},  // R3
    {2'b00, 32'h0000_0005, 1'b1, 3'd3},  // R3
    {2'b00, 32'h8000_0002, 1'b1, 3'd3},  // R4
    {2'b00, 32'h0000_0004, 1'b0, 3'd4},  // R4
    {2'b00, 32'hFFFF_FFFF, 1'b1, 3'd4},  // R4
    {2'b00, 32'h0000_0000, 1'b0, 3'd0},  // R3
    {2'b01, 32'h8000_0002, 1'b0, 3'd2},  // R5
    {2'b01, 32'h0000_000D, 1'b1, 3'd2},  // R5
    {2'b01, 32'h0000_0007, 1'b1, 3'd2},  // R5
    {2'b01, 32'hFFFF_FFFC, 1'b0, 3'd4},  // R5
    {2'b10, 32'h0000_0007, 1'b0, 3'd7},  // R6
    {2'b10, 32'hFFFF_FFF5, 1'b0, 3'd5},  // R6
    {2'b11, 32'h0000_0006, 1'b1, 3'd5},  // R7
    {2'b11, 32'h0000_0001, 1'b0, 3'd1},  // R7
    {2'b00, 32'h7FFF_FFFF, 1'b1, 3'd1},  // R4
    {2'b10, 32'h0000_0008, 1'b0, 3'd0}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 2'b00; wr_en = 1'b0; rd_en = 1'b0; wr_src = '0;
    step(); step();
    rst = 1'b0;
    check("R1 level", 32'(level), 32'd4);
    check("R1 rd_data", rd_data, 32'd4);
    check("R1 fault", 32'(fault), 32'd0);
    check("R1 wr_ok", 32'(wr_ok), 32'd0);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      mode = VEC[i][37:36]; wr_src = VEC[i][35:4]; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
      check("R8/R9 fault", 32'(fault), 32'(VEC[i][3]));
      check("R8/R9 wr_ok", 32'(wr_ok), 32'(!VEC[i][3]));
      check("R3-7 level", 32'(level), 32'(VEC[i][2:0]));
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      check("R8 pulse ends", 32'(fault | wr_ok), 32'd0);
      check("R2 read", rd_data, {29'd0, VEC[i][2:0]});
    end

    // R10: read and write together return old level (0)
    @(negedge clk);
    mode = 2'b10; wr_src = 32'h0000_0006; wr_en = 1'b1; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 old read", rd_data, 32'd0);
    check("R10 level", 32'(level), 32'd6);

    // R11: no write strobe, source and mode toggled
    @(negedge clk);
    mode = 2'b01; wr_src = 32'h0000_0001;
    step(); step();
    check("R11 hold", 32'(level), 32'd6);
    rd_en = 1'b1; step(); rd_en = 1'b0;
    check("R11 read", rd_data, 32'd6);

    // R2: read does not change without rd_en
    @(negedge clk);
    mode = 2'b10; wr_src = 32'h3; wr_en = 1'b1;
    step(); wr_en = 1'b0;
    check("R2 hold rd", rd_data, 32'd6);

    // R1: reset after activity
    @(negedge clk);
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 re-reset level", 32'(level), 32'd4);
    check("R1 re-reset rd", rd_data, 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule